// File: doc/BRIEF.md
# SMBus Alert Response Target

This block is the target-side responder for the SMBus alert mechanism. A one-cycle fault request from elsewhere in the chip latches a pending flag, and the block pulls the shared open-drain ALERT line low. It watches SCL and SDA, oversampled on the system clock, for the alert response broadcast. That broadcast is a read addressed to the fixed 7-bit value 0001100. When it arrives while an alert is pending, the block acknowledges it and then shifts its own 7-bit address onto SDA, so the bus controller learns which target raised the alert.

Several targets may answer the same broadcast. Each returned bit is arbitrated in the usual wired-AND way. A target that releases SDA to send a 1 but sees the line low has lost. It then releases the bus, keeps ALERT asserted and tries again on a later broadcast. A target that sends all eight bits without losing clears its pending flag and releases ALERT, unless a new fault request arrived during the transfer.

Both outputs are pull-down enables. A 1 means the pad drives the line low, and a 0 means the pad releases it.

Top module: `alert_resp_target`

## Requirements
- R1: A one-cycle high on `fault_set_i` sets the pending flag. `alert_pd_o` is 1 from the next clock and stays 1 until the block wins an alert response. After reset both outputs are 0.
- R2: START (SDA falls while SCL is high) restarts address reception from bit 0, also as a repeated START in the middle of a byte. STOP (SDA rises while SCL is high) releases SDA and returns the block to idle, and the pending flag is kept.
- R3: An address byte equal to 0x19 (address 0001100 followed by R/W = 1), sent MSB first, is acknowledged when the pending flag is set. The acknowledge holds SDA low for the whole ninth SCL pulse.
- R4: The block does not acknowledge, and leaves SDA released, in three cases: a read of the response address with no alert pending, the response address with R/W = 0 (0x18), or any other address.
- R5: After the acknowledge, the block sends the byte {own_addr_i[6:0], 1} MSB first. A 0 bit pulls SDA low and a 1 bit releases it.
- R6: If the block releases SDA for a 1 bit and samples SDA low on the rising SCL edge, it has lost arbitration. It releases SDA until the next START or STOP and keeps `alert_pd_o` at 1.
- R7: When all eight bits are sent without a loss, the pending flag clears and `alert_pd_o` drops right after the rising SCL edge of the eighth bit.
- R8: A fault request that arrives between the START and the winning eighth bit leaves `alert_pd_o` at 1 after the win.
- R9: `sda_pd_o` changes only while the synchronized SCL is low.
- R10: After the identification byte and the controller's ninth clock, the block stays released and ignores further clocks until a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| fault_set_i | input | 1 | One-cycle fault request |
| own_addr_i | input | 7 | Static address of this target |
| sda_pd_o | output | 1 | SDA pull-down enable |
| alert_pd_o | output | 1 | ALERT pull-down enable |

## Verification
The bench builds the block with its default parameters: a two-stage input synchronizer and the response address 0001100. The own address is tied to 0x5A, whose returned byte 10110101 begins with a released bit. That choice lets a rival answering with 0x2B win on the very first bit, while a rival answering with 0x6C loses on the second bit and leaves the block to finish the byte. The same address also lets a STOP be placed right after the acknowledge, because the block is released at that point. This covers a loss, a win against a live contender, an abort and a re-arm during a winning transfer.

// File: rtl/alert_resp_target.sv
module alert_resp_target #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] RESP_ADDR   = 7'b0001100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       fault_set_i,
  input  logic [6:0] own_addr_i,
  output logic       sda_pd_o,
  output logic       alert_pd_o
);

  localparam int         CNT_W    = 3;
  localparam logic [7:0] RESP_RD  = {RESP_ADDR, 1'b1};
  localparam logic [CNT_W-1:0] LAST = CNT_W'(7);

  typedef enum logic [2:0] {S_IDLE = 3'd0, S_ADDR = 3'd1, S_ACKW = 3'd2,
                            S_ACK = 3'd3, S_TX = 3'd4} st_t;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, bus_start, bus_stop;
  st_t  st;
  logic [CNT_W-1:0] cnt;
  logic [6:0] sh;
  logic sda_pd, pend, rearm;
  logic [7:0] tx_byte;
  logic addr_hit, lost, win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end

  assign scl_s     = scl_sync[SYNC_STAGES-1];
  assign sda_s     = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  assign tx_byte  = {own_addr_i, 1'b1};
  assign addr_hit = ({sh, sda_s} == RESP_RD) && pend;
  assign lost     = (st == S_TX) && scl_rise && !sda_pd && !sda_s;
  assign win      = (st == S_TX) && scl_rise && !lost && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      sda_pd <= 1'b0;
    end else if (bus_start) begin
      st     <= S_ADDR;
      cnt    <= '0;
      sda_pd <= 1'b0;
    end else if (bus_stop) begin
      st     <= S_IDLE;
      sda_pd <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: ;
        S_ADDR:
          if (scl_rise) begin
            sh  <= {sh[5:0], sda_s};
            cnt <= cnt + 1'b1;
            if (cnt == LAST) st <= addr_hit ? S_ACKW : S_IDLE;
          end
        S_ACKW:
          if (scl_fall) begin
            sda_pd <= 1'b1;
            st     <= S_ACK;
          end
        S_ACK:
          if (scl_fall) begin
            sda_pd <= ~tx_byte[7];
            cnt    <= '0;
            st     <= S_TX;
          end
        S_TX:
          if (scl_rise) begin
            if (lost) begin
              sda_pd <= 1'b0;
              st     <= S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
              if (cnt == LAST) st <= S_IDLE;
            end
          end else if (scl_fall) begin
            sda_pd <= ~tx_byte[LAST - cnt];
          end
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          rearm <= 1'b0;
    else if (win || bus_start || bus_stop) rearm <= 1'b0;
    else if (fault_set_i && st != S_IDLE)  rearm <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       pend <= 1'b0;
    else if (fault_set_i || (win && rearm)) pend <= 1'b1;
    else if (win)                     pend <= 1'b0;

  assign sda_pd_o   = sda_pd;
  assign alert_pd_o = pend;

endmodule

module alert_resp_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pd_o,
  input logic       alert_pd_o,
  input logic       fault_set_i,
  input logic       scl_s,
  input logic       scl_q,
  input logic       sda_s,
  input logic [2:0] st
);

  AST_FAULT_RAISES_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set_i |=> alert_pd_o); // R1

  AST_DRIVE_NEEDS_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd_o) |-> alert_pd_o); // R3

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pd_o) |-> !scl_s); // R9

  AST_LOSS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && scl_s && !scl_q && !sda_pd_o && !sda_s) |=> (!sda_pd_o && st == 3'd0)); // R6

  AST_ALERT_DROP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_pd_o) |-> (!sda_pd_o && !$past(fault_set_i))); // R7

endmodule

bind alert_resp_target alert_resp_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pd_o(sda_pd_o), .alert_pd_o(alert_pd_o),
  .fault_set_i(fault_set_i), .scl_s(scl_s), .scl_q(scl_q), .sda_s(sda_s), .st(st));

// File: tb/test_alert_resp_target.sv
`timescale 1ns/1ps
module test_alert_resp_target;
  localparam int H = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, ctl_pd = 1'b0, riv_pd = 1'b0, fault = 1'b0;
  logic sda_pd_o, alert_pd_o, sda_line;
  logic exp_sda = 1'b0, exp_alert = 1'b0;
  int settle = 0, checks = 0, errors = 0;
  string cur_req = "R1";
  logic m_pend = 1'b0, m_rearm = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = ~(sda_pd_o | ctl_pd | riv_pd);

  alert_resp_target i_alert_resp_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .fault_set_i(fault), .own_addr_i(OWN),
    .sda_pd_o(sda_pd_o), .alert_pd_o(alert_pd_o));

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n) begin
      if (settle > 0) settle--;
      else begin
        chk(sda_pd_o, exp_sda, cur_req, "sda_pd_o vs model");
        chk(alert_pd_o, exp_alert, cur_req, "alert_pd_o vs model");
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fault();
    fault = 1'b1; m_pend = 1'b1; exp_alert = 1'b1; settle = 6;
    tick(1);
    fault = 1'b0;
  endtask

  task automatic bus_start();
    ctl_pd = 1'b0; riv_pd = 1'b0; settle = 6; tick(H);
    if (!scl) begin scl = 1'b1; settle = 6; tick(H); end
    ctl_pd = 1'b1; settle = 6; tick(H);
    scl = 1'b0; settle = 6; tick(H);
  endtask

  task automatic bus_stop();
    ctl_pd = 1'b1; riv_pd = 1'b0; settle = 6; tick(H);
    scl = 1'b1; settle = 6; tick(H);
    ctl_pd = 1'b0; settle = 6; tick(H);
  endtask

  task automatic clk_bit(input logic cb, input logic rb, input logic nx,
                         input logic ra, output logic smp);
    logic p0;
    ctl_pd = ~cb; riv_pd = ~rb; settle = 6; tick(H);
    scl = 1'b1; exp_alert = ra; settle = 6; tick(4);
    p0 = sda_pd_o; smp = sda_line;
    tick(H - 4);
    chk(sda_pd_o, p0, "R9", "sda_pd_o stable while SCL high");
    scl = 1'b0; exp_sda = nx; settle = 6; tick(H);
  endtask

  task automatic alert_read(input logic [7:0] abyte, input int riv, input int fault_at,
                            input bit stop_after_ack, input bit extra);
    logic acked, smp, lost, rlost, lost_nx, d, r, de, nx, ra;
    logic [7:0] db, rb;
    acked = (abyte == 8'h19) && m_pend;
    m_rearm = 1'b0;
    db = {OWN, 1'b1};
    rb = {7'(riv), 1'b1};
    bus_start();
    for (int i = 0; i < 8; i++) begin
      nx = (i == 7) ? acked : 1'b0;
      clk_bit(abyte[7-i], 1'b1, nx, m_pend, smp);
    end
    if (!acked) begin
      clk_bit(1'b1, 1'b1, 1'b0, m_pend, smp);
      chk(smp, 1'b1, "R4", "no acknowledge");
      bus_stop();
      return;
    end
    clk_bit(1'b1, 1'b1, ~db[7], m_pend, smp);
    chk(smp, 1'b0, "R3", "acknowledge seen on ninth clock");
    if (stop_after_ack) begin
      bus_stop();
      return;
    end
    lost = 1'b0;
    rlost = (riv < 0);
    for (int i = 0; i < 8; i++) begin
      d  = db[7-i];
      de = lost ? 1'b1 : d;
      r  = rlost ? 1'b1 : rb[7-i];
      lost_nx = lost | (d & ~r);
      if (!rlost && r && !de) rlost = 1'b1;
      if (fault_at == i) begin pulse_fault(); m_rearm = 1'b1; end
      if (i == 7 && !lost_nx) m_pend = m_rearm;
      ra = m_pend;
      nx = (lost_nx || i == 7) ? 1'b0 : ~db[6-i];
      clk_bit(1'b1, r, nx, ra, smp);
      if (riv < 0) chk(smp, d, "R5", "identification bit on line");
      lost = lost_nx;
    end
    clk_bit(1'b1, 1'b1, 1'b0, m_pend, smp);
    if (extra)
      for (int i = 0; i < 9; i++) clk_bit(i[0], 1'b1, 1'b0, m_pend, smp);
    bus_stop();
  endtask

  initial begin
    logic smp;
    tick(3);
    chk(sda_pd_o, 1'b0, "R1", "reset sda_pd_o");
    chk(alert_pd_o, 1'b0, "R1", "reset alert_pd_o");
    rst_n = 1'b1;
    tick(5);

    cur_req = "R4"; alert_read(8'h19, -1, -1, 0, 0);
    chk(alert_pd_o, 1'b0, "R4", "no alert after unanswered read");

    cur_req = "R1"; pulse_fault(); tick(H);
    chk(alert_pd_o, 1'b1, "R1", "alert after fault");

    cur_req = "R4"; alert_read(8'h18, -1, -1, 0, 0);
    alert_read(8'h35, -1, -1, 0, 0);
    chk(alert_pd_o, 1'b1, "R4", "alert kept after ignored bytes");

    cur_req = "R2";
    bus_start();
    for (int i = 0; i < 3; i++) clk_bit(1'b0, 1'b1, 1'b0, m_pend, smp);
    cur_req = "R6"; alert_read(8'h19, 7'h2B, -1, 0, 0);
    chk(alert_pd_o, 1'b1, "R6", "alert kept after lost arbitration");

    cur_req = "R7"; alert_read(8'h19, 7'h6C, -1, 0, 0);
    chk(alert_pd_o, 1'b0, "R7", "alert released after winning against rival");

    cur_req = "R2"; pulse_fault(); tick(H);
    alert_read(8'h19, -1, -1, 1, 0);
    chk(alert_pd_o, 1'b1, "R2", "alert kept after STOP following acknowledge");
    chk(sda_pd_o, 1'b0, "R2", "SDA released after STOP");

    cur_req = "R8"; alert_read(8'h19, -1, 3, 0, 0);
    chk(alert_pd_o, 1'b1, "R8", "re-armed by fault during transfer");

    cur_req = "R10"; alert_read(8'h19, -1, -1, 0, 1);
    chk(alert_pd_o, 1'b0, "R7", "alert released after clean win");
    chk(sda_pd_o, 1'b0, "R10", "released after extra clocks");

    cur_req = "R5"; pulse_fault(); tick(H);
    alert_read(8'h19, -1, 7, 0, 0);
    chk(alert_pd_o, 1'b1, "R8", "fault on last bit re-arms");
    alert_read(8'h19, -1, -1, 0, 0);
    chk(alert_pd_o, 1'b0, "R7", "final clear");

    tick(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule